// File: doc/BRIEF.md
# Logic Self-Test Sequencer with Parallel Scan Chains

This block runs a complete logic self-test session over a set of parallel scan chains. A pulse on `start` loads a 16-bit pseudo-random generator from the `seed` input and clears a 16-bit signature register. The block then runs a programmed number of patterns. Each pattern is one load pass with `scan_en` high, lasting one cycle per chain bit. It is followed by a programmable number of functional capture cycles with `scan_en` low. While each load pass shifts new stimulus into the chains, the signature register folds in the responses that leave them.

After the last capture the block runs one extra unload pass with no further capture, so that the final responses also reach the signature. It then raises `done` and reports `pass` when the signature equals the `golden` input. The scan stream has no handshake. Each chain moves exactly one bit in each cycle that `scan_en` is high, and the chains under test must accept and present a bit in every such cycle. There is no back-pressure: the sequencer never stalls mid-pass.

Top module: `lbist_ctrl`

## Requirements
- R1: After reset, `done`, `pass` and `scan_en` are low, and the block stays idle until `start`.
- R2: A `start` seen while idle or done begins a session. `pat_count` and `cap_count` are captured at that edge, and later changes to them have no effect on that session's cycle counts or signature.
- R3: Each pattern is CHAIN_LEN cycles with `scan_en` high followed by C cycles with `scan_en` low, where C is `cap_count` and a value of 0 counts as 1. A session of P patterns therefore shows (P+1)·CHAIN_LEN shift cycles and P·C capture cycles.
- R4: The generator uses the feedback `q[15]^q[13]^q[12]^q[10]` shifted into bit 0 (taps 16, 14, 13, 11). It is loaded from `seed` at start and steps once per shift cycle. Chain i receives `q[i] ^ q[(i+5) mod 16]`, so in the first shift cycle `chain_si` reflects the seed itself.
- R5: A `seed` of zero is replaced by 0x0001.
- R6: The signature starts at zero. Each shift cycle it becomes `{m[14:0], m[15]^m[13]^m[12]^m[10]}` XOR `chain_so` placed in bits NCH-1..0. It holds during capture.
- R7: After the last capture there is one unload pass of CHAIN_LEN shift cycles with no capture. With `pat_count` = 0 the session is that unload pass alone.
- R8: `done` rises after the unload pass and stays high until the next `start`. `pass` is high only while `done` is high and the signature equals `golden`.
- R9: A single flipped response bit on any shift cycle makes `pass` low against the signature of the unflipped session.
- R10: The generator state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session |
| pat_count | input | PCNT_W | Number of patterns |
| cap_count | input | CAPW | Capture cycles per pattern (0 means 1) |
| seed | input | 16 | Generator seed |
| golden | input | 16 | Expected signature |
| chain_so | input | NCH | Serial outputs of the chains |
| chain_si | output | NCH | Serial inputs to the chains |
| scan_en | output | 1 | High on shift cycles |
| done | output | 1 | Session finished |
| pass | output | 1 | Signature matched golden |

## Verification
A wrong generator or signature state is never visible cycle by cycle. It surfaces only at the end of the session, as a `pass` that disagrees with a signature predicted from the polynomial definitions and a modelled set of chains. A wrong sequencer count shows at once in the number of high and low `scan_en` cycles between `start` and `done`. A bad seed load is visible on `chain_si` in the first shift cycle.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int SIG_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPT,
    ST_UNLOAD,
    ST_DONE
  } lbist_st_t;

  // one step of x^16 + x^14 + x^13 + x^11 + 1, shifting toward the MSB
  function automatic logic [SIG_W-1:0] poly_step(input logic [SIG_W-1:0] v);
    return {v[SIG_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
  import lbist_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PH_OFS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SIG_W-1:0] seed,
  input  logic             step,
  output logic [SIG_W-1:0] state,
  output logic [NCH-1:0]   si
);
  logic [SIG_W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= SIG_W'(1);
    else if (load) q <= (seed == '0) ? SIG_W'(1) : seed;
    else if (step) q <= poly_step(q);
  end

  // phase shifter: each chain sees the XOR of two generator taps
  for (genvar i = 0; i < NCH; i++) begin : g_phase
    localparam int TA = i % SIG_W;
    localparam int TB = (i + PH_OFS) % SIG_W;
    assign si[i] = q[TA] ^ q[TB];
  end

  assign state = q;
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
  import lbist_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             absorb,
  input  logic [NCH-1:0]   so,
  output logic [SIG_W-1:0] sig
);
  logic [SIG_W-1:0] inj;

  always_comb begin
    inj = '0;
    for (int i = 0; i < NCH; i++) inj[i] = so[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sig <= '0;
    else if (absorb)     sig <= poly_step(sig) ^ inj;
  end
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PCNT_W    = 8,
  parameter int CAPW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PCNT_W-1:0] pat_count,
  input  logic [CAPW-1:0]   cap_count,
  output logic              init,
  output logic              shift_act,
  output logic              busy,
  output logic              done
);
  localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(CHAIN_LEN - 1);

  lbist_st_t         st;
  logic [BW-1:0]     bit_cnt;
  logic [CAPW-1:0]   cap_cnt, cap_lat, cap_end;
  logic [PCNT_W-1:0] pat_cnt, pat_lat;

  assign init    = start && (st == ST_IDLE || st == ST_DONE);
  assign cap_end = (cap_lat == '0) ? '0 : cap_lat - CAPW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      cap_cnt <= '0;
      pat_cnt <= '0;
      pat_lat <= '0;
      cap_lat <= '0;
    end else if (init) begin
      pat_lat <= pat_count;
      cap_lat <= cap_count;
      pat_cnt <= '0;
      bit_cnt <= '0;
      cap_cnt <= '0;
      st      <= (pat_count == '0) ? ST_UNLOAD : ST_SHIFT;
    end else begin
      case (st)
        ST_SHIFT: begin
          if (bit_cnt == BIT_LAST) begin
            bit_cnt <= '0;
            cap_cnt <= '0;
            st      <= ST_CAPT;
          end else bit_cnt <= bit_cnt + BW'(1);
        end
        ST_CAPT: begin
          if (cap_cnt == cap_end) begin
            cap_cnt <= '0;
            pat_cnt <= pat_cnt + PCNT_W'(1);
            st      <= (pat_cnt + PCNT_W'(1) == pat_lat) ? ST_UNLOAD : ST_SHIFT;
          end else cap_cnt <= cap_cnt + CAPW'(1);
        end
        ST_UNLOAD: begin
          if (bit_cnt == BIT_LAST) begin
            bit_cnt <= '0;
            st      <= ST_DONE;
          end else bit_cnt <= bit_cnt + BW'(1);
        end
        default: ;
      endcase
    end
  end

  assign shift_act = (st == ST_SHIFT) || (st == ST_UNLOAD);
  assign busy      = shift_act || (st == ST_CAPT);
  assign done      = (st == ST_DONE);
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CHAIN_LEN = 8,
  parameter int PCNT_W    = 8,
  parameter int CAPW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PCNT_W-1:0] pat_count,
  input  logic [CAPW-1:0]   cap_count,
  input  logic [SIG_W-1:0]  seed,
  input  logic [SIG_W-1:0]  golden,
  input  logic [NCH-1:0]    chain_so,
  output logic [NCH-1:0]    chain_si,
  output logic              scan_en,
  output logic              done,
  output logic              pass
);
  logic             init, shift_act, busy;
  logic [SIG_W-1:0] lfsr_q, sig_q;

  lbist_seq #(.CHAIN_LEN(CHAIN_LEN), .PCNT_W(PCNT_W), .CAPW(CAPW)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .cap_count(cap_count), .init(init), .shift_act(shift_act),
    .busy(busy), .done(done)
  );

  lbist_prpg #(.NCH(NCH)) i_prpg (
    .clk(clk), .rst_n(rst_n), .load(init), .seed(seed),
    .step(shift_act), .state(lfsr_q), .si(chain_si)
  );

  lbist_misr #(.NCH(NCH)) i_misr (
    .clk(clk), .rst_n(rst_n), .clear(init), .absorb(shift_act),
    .so(chain_so), .sig(sig_q)
  );

  assign scan_en = shift_act;
  assign pass    = done && (sig_q == golden);
endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk #(
  parameter int CAPW = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        scan_en,
  input logic        done,
  input logic        pass,
  input logic        busy,
  input logic [15:0] lfsr_q
);
  localparam int MAXC = 1 << CAPW;
  logic [CAPW:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || scan_en) low_run <= '0;
    else                            low_run <= low_run + 1'b1;
  end

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !scan_en); // R1
  AST_START_RUNS:    assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_CAPT_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) low_run < (CAPW+1)'(MAXC)); // R3
  AST_DONE_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R8
  AST_PASS_DONE:     assert property (@(posedge clk) disable iff (!rst_n) pass |-> done); // R8
  AST_LFSR_LIVE:     assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 16'h0000); // R10
endmodule

bind lbist_ctrl lbist_ctrl_chk #(.CAPW(CAPW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en), .done(done),
  .pass(pass), .busy(busy), .lfsr_q(lfsr_q)
);

// File: tb/test_lbist_ctrl.sv
module test_lbist_ctrl;
  localparam int NCH = 4;
  localparam int L   = 8;
  localparam int PW  = 8;
  localparam int CW  = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [PW-1:0] pat_count = '0;
  logic [CW-1:0] cap_count = '0;
  logic [15:0]   seed = '0, golden = '0;
  logic [NCH-1:0] chain_so, chain_si;
  logic          scan_en, done, pass;

  int nchk = 0, nbad = 0;
  int sh = 0, cp = 0;
  logic in_run = 0, cut_clr = 0, flip_on = 0;
  logic [L-1:0] cut [NCH];

  always #2 clk = ~clk;

  lbist_ctrl #(.NCH(NCH), .CHAIN_LEN(L), .PCNT_W(PW), .CAPW(CW)) i_lbist_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .cap_count(cap_count), .seed(seed), .golden(golden), .chain_so(chain_so),
    .chain_si(chain_si), .scan_en(scan_en), .done(done), .pass(pass)
  );

  function automatic logic [15:0] ref_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [L-1:0] capf(input logic [L-1:0] a, input logic [L-1:0] b);
    return {a[L-2:0], a[L-1]} ^ (b & ~a);
  endfunction

  function automatic logic [NCH-1:0] phase(input logic [15:0] r);
    logic [NCH-1:0] s;
    for (int i = 0; i < NCH; i++) s[i] = r[i] ^ r[(i + 5) % 16];
    return s;
  endfunction

  // the circuit under test: NCH chains with a simple capture function
  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (cut_clr)      cut[i] <= '0;
      else if (scan_en) cut[i] <= {cut[i][L-2:0], chain_si[i]};
      else if (in_run)  cut[i] <= capf(cut[i], cut[(i + 1) % NCH]);
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) chain_so[i] = cut[i][L-1];
    chain_so[0] = cut[0][L-1] ^ (flip_on && sh == 3);
  end

  function automatic logic [15:0] model_sig(input logic [15:0] sd, input int np, input int nc);
    logic [15:0] r, m;
    logic [L-1:0] c [NCH];
    logic [L-1:0] n [NCH];
    logic [NCH-1:0] s, f;
    int ce;
    r  = (sd == 0) ? 16'h0001 : sd;
    m  = '0;
    ce = (nc == 0) ? 1 : nc;
    for (int i = 0; i < NCH; i++) c[i] = '0;
    for (int p = 0; p <= np; p++) begin
      for (int b = 0; b < L; b++) begin
        for (int i = 0; i < NCH; i++) s[i] = c[i][L-1];
        m = ref_step(m) ^ {{(16-NCH){1'b0}}, s};
        f = phase(r);
        for (int i = 0; i < NCH; i++) c[i] = {c[i][L-2:0], f[i]};
        r = ref_step(r);
      end
      if (p < np)
        for (int k = 0; k < ce; k++) begin
          for (int i = 0; i < NCH; i++) n[i] = capf(c[i], c[(i + 1) % NCH]);
          c = n;
        end
    end
    return m;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [NCH-1:0] first_si;

  task automatic run(input logic [15:0] sd, input int np, input int nc,
                     input logic [15:0] gold, input logic flip, input logic mid);
    @(negedge clk);
    cut_clr = 1;
    @(negedge clk);
    cut_clr = 0;
    seed = sd; pat_count = PW'(np); cap_count = CW'(nc); golden = gold;
    sh = 0; cp = 0; flip_on = flip;
    start = 1;
    @(negedge clk);
    start = 0;
    in_run = 1;
    first_si = chain_si;
    while (!done) begin
      if (scan_en) sh++; else cp++;
      if (mid && sh == 3) begin pat_count = PW'(np + 7); cap_count = CW'(nc + 2); end
      @(negedge clk);
    end
    in_run = 0;
    flip_on = 0;
  endtask

  localparam logic [31:0] VEC [7] = '{
    {16'hACE1, 8'd3, 8'd1},
    {16'h0000, 8'd2, 8'd2},
    {16'h0001, 8'd2, 8'd2},
    {16'hFFFF, 8'd0, 8'd1},
    {16'h1234, 8'd5, 8'd0},
    {16'h8001, 8'd4, 8'd3},
    {16'h5A5A, 8'd1, 8'd7}
  };

  initial begin
    #(200000 * 4);
    nbad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !pass && !scan_en, "R1 reset state", {done, pass, scan_en}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!done && !scan_en, "R1 idle without start", {done, scan_en}, 0);

    for (int v = 0; v < 7; v++) begin
      logic [15:0] sd, g, sdx;
      int np, nc, ce;
      sd = VEC[v][31:16]; np = int'(VEC[v][15:8]); nc = int'(VEC[v][2:0]);
      ce = (nc == 0) ? 1 : nc;
      sdx = (sd == 0) ? 16'h0001 : sd;
      g = model_sig(sd, np, nc);
      run(sd, np, nc, g, 0, 0);
      chk(sh == (np + 1) * L, "R3 R7 shift cycles", sh, (np + 1) * L);
      chk(cp == np * ce, "R3 capture cycles", cp, np * ce);
      chk(first_si == phase(sdx), "R4 R5 first chain inputs", first_si, phase(sdx));
      chk(done && pass, "R6 R8 signature pass", pass, 1);
      golden = g ^ (16'h1 << v);
      @(negedge clk);
      chk(!pass && done, "R8 wrong golden fails", pass, 0);
      golden = g;
      @(negedge clk);
      chk(pass, "R8 pass follows golden", pass, 1);
    end

    begin
      logic [15:0] g;
      g = model_sig(16'h0000, 3, 2);
      chk(g == model_sig(16'h0001, 3, 2), "R5 zero seed model", g, model_sig(16'h0001, 3, 2));
      run(16'h0000, 3, 2, model_sig(16'h0001, 3, 2), 0, 0);
      chk(pass, "R5 zero seed acts as one", pass, 1);

      g = model_sig(16'hC0DE, 2, 3);
      run(16'hC0DE, 2, 3, g, 0, 1);
      chk(sh == 3 * L && cp == 6, "R2 counts latched at start", sh * 100 + cp, 3 * L * 100 + 6);
      chk(pass, "R2 signature unaffected by input change", pass, 1);

      g = model_sig(16'h0F0F, 3, 1);
      run(16'h0F0F, 3, 1, g, 1, 0);
      chk(done && !pass, "R9 flipped response bit fails", pass, 0);

      repeat (5) @(negedge clk);
      chk(done, "R8 done held until start", done, 1);

      run(16'hBEEF, 0, 4, model_sig(16'hBEEF, 0, 4), 0, 0);
      chk(sh == L && cp == 0, "R7 zero patterns unload only", sh * 100 + cp, L * 100);
      chk(pass, "R7 zero pattern signature", pass, 1);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule